// File: doc/BRIEF.md
# Deferred Read-Based Refresh Scheduler

This block keeps the contents of a DRAM alive without ever sending the device a dedicated refresh command. The memory is split into independent bank groups, and each group is served in its own time slot. For every group the block runs a due timer and a row pointer. When the timer expires, the group owes one refresh. The block waits until the group's client transaction is over. It then takes the group's next slot and issues an ordinary read of the next row in sequence. A read of a row restores that row's charge, so each interruption lasts only as long as one short access.

The refresh interval equals the retention window divided by the row count, scaled down by a margin percentage. The margin leaves enough slack that a refresh held back by a client transaction still lands inside the retention window. Expiries that cannot be served at once are counted in a small backlog. The client arbiter sees a per-group hold flag. While the flag is set, the arbiter does not start a new transaction in that group, and the block injects a row address plus a valid strobe in place of the client. The command generator downstream is not part of this block.

Top module: `rfsh_read_sched`

## Requirements
- R1: After reset, `refresh_due`, `client_hold` and `inj_valid` are all 0 for every group, and the first row injected for any group is row 0.
- R2: The interval is I = WINDOW_CYCLES*MARGIN_PCT/(100*ROWS) cycles. Counting the first rising edge that samples reset low as edge 1, a group with no backlog raises `refresh_due` after edge I+1, and not before.
- R3: A refresh read is injected only on an edge that samples `slot_start[g]`=1 while `client_hold[g]`=1 and `client_busy[g]`=0. `inj_valid[g]` is then 1 for exactly the following cycle. If that read empties the backlog, `refresh_due[g]` and `client_hold[g]` fall after the same edge.
- R4: While `client_busy[g]`=1, the group gets no hold and no injection, even when refresh is due. `client_hold[g]` rises after the first edge that samples busy low, and the next slot is then taken for the refresh.
- R5: Each group's injected row numbers run 0, 1, ..., ROWS-1 and then wrap to 0. The row advances by one per injected read.
- R6: Groups are independent. Busy, slot and injection activity in one group changes neither the flags nor the row sequence of another group.
- R7: Expiries that are not yet served accumulate, up to 3. Each injected read retires one of them, and `refresh_due` stays 1 until all are retired.
- R8: When a timer expiry and an injection fall on the same edge, the backlog count does not change, and `refresh_due` and `client_hold` stay 1.
- R9: Given slots that recur at least every few cycles, and client transactions much shorter than I, every row of every group is read again within WINDOW_CYCLES cycles of its previous refresh, or of reset.
- R10: `client_hold[g]` is 1 only while `refresh_due[g]` is 1 and the last sampled `client_busy[g]` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | GROUPS | One-cycle pulse when a group's time slot begins |
| client_busy | input | GROUPS | The group's client transaction is in progress |
| refresh_due | output | GROUPS | At least one refresh is owed by the group |
| client_hold | output | GROUPS | Arbiter must not start a client transaction; the next slot is reserved for refresh |
| inj_valid | output | GROUPS | One-cycle strobe: a refresh read is injected into this slot |
| inj_row | output | GROUPS*ROW_W | Row address of the injected read, ROW_W bits per group, group 0 in the low bits |

## Verification
Two functions can fall on the same edge: a timer expiry that adds to the backlog, and an injected read that retires an entry from it. The bench provokes this by holding back the first owed refresh until the slot pulse sits exactly on the edge that samples the second expiry. It then expects a read of row 0 with `refresh_due` and `client_hold` still high, followed by a read of row 1 on the next slot that clears both flags. A long sweep then combines client transactions of varying length with periodic slots. During the sweep the bench measures, at the ports, the gap between successive reads of each row against the window.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Cycles between refresh reads of one group: window/rows scaled by margin.
  function automatic int unsigned refresh_interval(
      input longint unsigned window_cycles,
      input int unsigned     rows,
      input int unsigned     margin_pct);
    longint unsigned v;
    v = (window_cycles * longint'(margin_pct)) / (100 * longint'(rows));
    if (v < 2) v = 2;
    return int'(v);
  endfunction

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rfsh_due_timer.sv
module rfsh_due_timer #(
  parameter int unsigned INTERVAL = 16
) (
  input  logic clk,
  input  logic rst,
  output logic expire
);
  localparam int unsigned CNT_W = $clog2(INTERVAL);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= (cnt == LAST);
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rfsh_row_seq.sv
module rfsh_row_seq #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst)          row <= '0;
    else if (advance) row <= (row == TOP) ? '0 : row + ROW_W'(1);
  end
endmodule

// File: rtl/rfsh_slot_claim.sv
module rfsh_slot_claim #(
  parameter int unsigned BACKLOG_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic slot_start,
  input  logic client_busy,
  output logic take,
  output logic due,
  output logic hold
);
  localparam logic [BACKLOG_W-1:0] OWE_MAX = '1;

  logic [BACKLOG_W-1:0] owed, owed_n;

  assign take = slot_start & hold & ~client_busy;

  always_comb begin
    owed_n = owed;
    if (expire && !take) begin
      if (owed != OWE_MAX) owed_n = owed + BACKLOG_W'(1);
    end else if (take && !expire) begin
      owed_n = owed - BACKLOG_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed <= '0;
      due  <= 1'b0;
      hold <= 1'b0;
    end else begin
      owed <= owed_n;
      due  <= (owed_n != '0);
      hold <= (owed_n != '0) && !client_busy;
    end
  end
endmodule

// File: rtl/rfsh_read_sched.sv
module rfsh_read_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned GROUPS        = 4,
  parameter int unsigned ROWS          = 64,
  parameter int unsigned WINDOW_CYCLES = 3_200_000,
  parameter int unsigned MARGIN_PCT    = 90,
  parameter int unsigned BACKLOG_W     = 2,
  localparam int unsigned ROW_W        = bits_for(ROWS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [GROUPS-1:0]       slot_start,
  input  logic [GROUPS-1:0]       client_busy,
  output logic [GROUPS-1:0]       refresh_due,
  output logic [GROUPS-1:0]       client_hold,
  output logic [GROUPS-1:0]       inj_valid,
  output logic [GROUPS*ROW_W-1:0] inj_row
);
  localparam int unsigned INTERVAL =
    refresh_interval(longint'(WINDOW_CYCLES), ROWS, MARGIN_PCT);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic             expire;
    logic             take;
    logic [ROW_W-1:0] row;

    rfsh_due_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .expire (expire)
    );

    rfsh_slot_claim #(.BACKLOG_W(BACKLOG_W)) u_claim (
      .clk         (clk),
      .rst         (rst),
      .expire      (expire),
      .slot_start  (slot_start[g]),
      .client_busy (client_busy[g]),
      .take        (take),
      .due         (refresh_due[g]),
      .hold        (client_hold[g])
    );

    rfsh_row_seq #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
      .clk     (clk),
      .rst     (rst),
      .advance (take),
      .row     (row)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        inj_valid[g]                 <= 1'b0;
        inj_row[g*ROW_W +: ROW_W]    <= '0;
      end else begin
        inj_valid[g] <= take;
        if (take) inj_row[g*ROW_W +: ROW_W] <= row;
      end
    end
  end
endmodule

// File: rtl/rfsh_read_sched_chk.sv
module rfsh_read_sched_chk
  import rfsh_pkg::*;
#(
  parameter int unsigned GROUPS        = 4,
  parameter int unsigned ROWS          = 64,
  parameter int unsigned WINDOW_CYCLES = 3_200_000,
  parameter int unsigned ROW_W         = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [GROUPS-1:0]       slot_start,
  input logic [GROUPS-1:0]       client_busy,
  input logic [GROUPS-1:0]       refresh_due,
  input logic [GROUPS-1:0]       client_hold,
  input logic [GROUPS-1:0]       inj_valid,
  input logic [GROUPS*ROW_W-1:0] inj_row
);
  localparam int unsigned AGE_W = $clog2(WINDOW_CYCLES) + 2;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(WINDOW_CYCLES);

  logic [AGE_W-1:0] age [GROUPS][ROWS];
  logic             over_window;

  // Cycles since each row was last read (or since reset).
  always_ff @(posedge clk) begin
    for (int g = 0; g < GROUPS; g++) begin
      for (int r = 0; r < ROWS; r++) begin
        if (rst)
          age[g][r] <= '0;
        else if (inj_valid[g] && inj_row[g*ROW_W +: ROW_W] == ROW_W'(r))
          age[g][r] <= '0;
        else if (age[g][r] != AGE_MAX)
          age[g][r] <= age[g][r] + AGE_W'(1);
      end
    end
  end

  always_comb begin
    over_window = 1'b0;
    for (int g = 0; g < GROUPS; g++)
      for (int r = 0; r < ROWS; r++)
        if (age[g][r] > AGE_LIM) over_window = 1'b1;
  end

  // R9: no row goes longer than the window without a read
  assert_retention_R9: assert property (@(posedge clk) disable iff (rst)
    !over_window);

  // R1: flags quiet on the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (refresh_due == '0) && (inj_valid == '0) && (client_hold == '0));

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    logic [ROW_W-1:0] last_row;
    logic             seen;
    logic [ROW_W-1:0] want_row;

    always_ff @(posedge clk) begin
      if (rst) begin
        last_row <= '0;
        seen     <= 1'b0;
      end else if (inj_valid[g]) begin
        last_row <= inj_row[g*ROW_W +: ROW_W];
        seen     <= 1'b1;
      end
    end

    always_comb begin
      if (!seen)                               want_row = '0;
      else if (last_row == ROW_W'(ROWS - 1))   want_row = '0;
      else                                     want_row = last_row + ROW_W'(1);
    end

    // R5 and R1: row sequence starts at 0, steps by one, wraps
    assert_row_step_R5: assert property (@(posedge clk) disable iff (rst)
      inj_valid[g] |-> inj_row[g*ROW_W +: ROW_W] == want_row);

    // R3: injection only after a slot with hold set and client idle
    assert_inj_cause_R3: assert property (@(posedge clk) disable iff (rst)
      inj_valid[g] |-> $past(slot_start[g]) && $past(client_hold[g]) && !$past(client_busy[g]));

    // R4: a busy client is never displaced
    assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (rst)
      client_busy[g] |=> !inj_valid[g]);

    // R10: hold only while a refresh is owed
    assert_hold_due_R10: assert property (@(posedge clk) disable iff (rst)
      client_hold[g] |-> refresh_due[g]);
  end
endmodule

bind rfsh_read_sched rfsh_read_sched_chk #(
  .GROUPS(GROUPS), .ROWS(ROWS), .WINDOW_CYCLES(WINDOW_CYCLES), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst(rst), .slot_start(slot_start), .client_busy(client_busy),
  .refresh_due(refresh_due), .client_hold(client_hold),
  .inj_valid(inj_valid), .inj_row(inj_row)
);

// File: tb/tb_rfsh_read_sched.sv
module tb_rfsh_read_sched;
  localparam int G   = 2;
  localparam int NR  = 4;
  localparam int WIN = 400;
  localparam int MRG = 80;
  localparam int RW  = 2;
  localparam int I   = WIN * MRG / (100 * NR);   // 80 cycles

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [G-1:0] man_slot = '0, man_busy = '0, auto_slot, auto_busy;
  logic auto_en = 1'b0;
  wire  [G-1:0] slot_start  = auto_en ? auto_slot : man_slot;
  wire  [G-1:0] client_busy = auto_en ? auto_busy : man_busy;
  wire  [G-1:0] refresh_due, client_hold, inj_valid;
  wire  [G*RW-1:0] inj_row;

  rfsh_read_sched #(.GROUPS(G), .ROWS(NR), .WINDOW_CYCLES(WIN),
                    .MARGIN_PCT(MRG), .BACKLOG_W(2)) dut (
    .clk(clk), .rst(rst), .slot_start(slot_start), .client_busy(client_busy),
    .refresh_due(refresh_due), .client_hold(client_hold),
    .inj_valid(inj_valid), .inj_row(inj_row));

  int cyc = 0;
  int nchk = 0, nfail = 0;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // background stimulus for the sweep
  always_comb begin
    for (int g = 0; g < G; g++) begin
      auto_slot[g] = ((cyc % 8) == g * 4);
      auto_busy[g] = (g == 0) ? ((cyc % 40) < 20) : ((cyc % 30) < 10);
    end
  end

  function automatic int row_of(input int g);
    return int'(inj_row[g*RW +: RW]);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic do_reset();
    auto_en = 1'b0; man_slot = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic goto(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  // slot pulse sampled on edge e; returns at the negedge after edge e
  task automatic slot_at(input int g, input int e);
    goto(e - 1);
    man_slot[g] = 1'b1;
    @(negedge clk);
    man_slot[g] = 1'b0;
  endtask

  task automatic t_reset_and_timer();
    man_busy = '0;
    do_reset();
    chk("R1", "due after reset", int'(refresh_due), 0);
    chk("R1", "hold after reset", int'(client_hold), 0);
    chk("R1", "inj after reset", int'(inj_valid), 0);
    goto(I);
    chk("R2", "due before interval", int'(refresh_due), 0);
    goto(I + 1);
    chk("R2", "due after interval", int'(refresh_due), 3);
    chk("R10", "hold with idle client", int'(client_hold), 3);
    slot_at(0, I + 3);
    chk("R3", "inj g0", int'(inj_valid), 1);
    chk("R1", "first row g0", row_of(0), 0);
    chk("R3", "due g0 cleared", int'(refresh_due[0]), 0);
    chk("R3", "hold g0 cleared", int'(client_hold[0]), 0);
    chk("R6", "g1 still due", int'(refresh_due[1]), 1);
    @(negedge clk);
    chk("R3", "inj one cycle", int'(inj_valid), 0);
  endtask

  task automatic t_deferral();
    man_busy = 2'b01;
    do_reset();
    goto(I + 1);
    chk("R4", "due while busy", int'(refresh_due[0]), 1);
    chk("R4", "no hold while busy", int'(client_hold[0]), 0);
    chk("R6", "g1 hold unaffected", int'(client_hold[1]), 1);
    slot_at(0, I + 3);
    chk("R4", "no inj while busy", int'(inj_valid[0]), 0);
    goto(I + 4);
    man_busy[0] = 1'b0;
    @(negedge clk);
    chk("R4", "hold after busy ends", int'(client_hold[0]), 1);
    slot_at(0, I + 7);
    chk("R4", "inj after busy ends", int'(inj_valid[0]), 1);
    chk("R4", "row after deferral", row_of(0), 0);
  endtask

  task automatic t_wrap();
    man_busy = '0;
    do_reset();
    for (int k = 1; k <= 5; k++) begin
      slot_at(0, k * I + 3);
      chk("R5", "inj g0", int'(inj_valid[0]), 1);
      chk("R5", "row g0", row_of(0), (k - 1) % NR);
      chk("R6", "g1 idle during g0 inj", int'(inj_valid[1]), 0);
      slot_at(1, k * I + 5);
      chk("R6", "row g1", row_of(1), (k - 1) % NR);
    end
  endtask

  task automatic t_coincide();
    man_busy = '0;
    do_reset();
    slot_at(0, 2 * I + 1);
    chk("R8", "inj on expiry edge", int'(inj_valid[0]), 1);
    chk("R8", "row on expiry edge", row_of(0), 0);
    chk("R8", "due kept", int'(refresh_due[0]), 1);
    chk("R8", "hold kept", int'(client_hold[0]), 1);
    slot_at(0, 2 * I + 3);
    chk("R8", "second row", row_of(0), 1);
    chk("R8", "due cleared", int'(refresh_due[0]), 0);
  endtask

  task automatic t_backlog();
    man_busy = 2'b01;
    do_reset();
    goto(2 * I + 1);
    chk("R7", "due with backlog", int'(refresh_due[0]), 1);
    man_busy[0] = 1'b0;
    slot_at(0, 2 * I + 4);
    chk("R7", "first backlog row", row_of(0), 0);
    chk("R7", "due after first", int'(refresh_due[0]), 1);
    slot_at(0, 2 * I + 6);
    chk("R7", "second backlog row", row_of(0), 1);
    chk("R7", "due after second", int'(refresh_due[0]), 0);
    slot_at(0, 2 * I + 8);
    chk("R7", "no third inj", int'(inj_valid[0]), 0);
  endtask

  int last_t [G][NR];
  int want_r [G];
  int ninj   [G];

  always @(negedge clk) begin
    if (auto_en && !rst) begin
      for (int g = 0; g < G; g++) begin
        if (inj_valid[g]) begin
          chk("R9", "row refresh gap within window",
              (cyc - last_t[g][row_of(g)] <= WIN) ? 1 : 0, 1);
          chk("R5", "sweep row order", row_of(g), want_r[g]);
          last_t[g][row_of(g)] = cyc;
          want_r[g] = (want_r[g] + 1) % NR;
          ninj[g]++;
        end
      end
    end
  end

  task automatic t_sweep();
    do_reset();
    for (int g = 0; g < G; g++) begin
      want_r[g] = 0; ninj[g] = 0;
      for (int r = 0; r < NR; r++) last_t[g][r] = 0;
    end
    auto_en = 1'b1;
    goto(6 * WIN);
    auto_en = 1'b0;
    for (int g = 0; g < G; g++)
      chk("R9", "refresh count in sweep", (ninj[g] >= 28) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset_and_timer();
    t_deferral();
    t_wrap();
    t_coincide();
    t_backlog();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule